// File: doc/BRIEF.md
# SPI Master Frame Timing Sequencer

This block produces the serial clock and the chip-select waveform of an SPI master from a single system clock. A set of static configuration inputs chooses the SCK rate (a small odd prescaler, a scaler from a doubling table and a double-rate bit) and three chip-select delays. Each of the three delays is an odd prescaler times a power-of-two scaler. The three delays are the set-up time from chip-select assertion to the first SCK edge, the hold time from the last SCK edge to chip-select release, and the idle gap between frames.

A one-cycle start request begins a frame. The block lowers the chip select, waits the set-up delay, and emits the programmed number of SCK pulses. It waits the hold delay, raises the chip select, and then keeps the gap before another frame may begin. The shift logic alongside uses two single-cycle strobes, one marking each rising and one marking each falling SCK edge. A busy flag covers the whole frame, including its trailing gap. In continuous-clock mode the gap is one SCK period and the delay-after-transfer fields are not used. SCK idles low.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset, and whenever busy is low, cs_n is 1, sck is 0 and both strobes are 0.
- R2: The SCK period in system clocks is P = prescale × scale / (1 + dbl_rate). The prescaler codes 0,1,2,3 give 1,3,5,7. The baud scaler codes 0,1,2 give 2,4,6, and any code c ≥ 3 gives 2^c (8 up to 32768).
- R3: Within a frame each SCK high phase lasts ceil(P/2) clocks and each low phase lasts floor(P/2) clocks. A computed P below 2 is raised to 2.
- R4: A delay scaler code n gives 2^(n+1) clocks (2 up to 65536), and each delay is its prescaler value times that. The set-up delay runs from cs_n falling to the first SCK rise.
- R5: A frame contains exactly frame_len + 1 SCK rising edges, and SCK is high only while cs_n is low.
- R6: The hold delay runs from the last SCK fall to cs_n rising.
- R7: With continuous-clock mode off, the gap (delay-after-transfer prescaler × scaler) runs from cs_n rising to the next cs_n fall when a request is waiting, or otherwise to busy falling.
- R8: With continuous-clock mode on, the gap equals P clocks whatever the delay-after-transfer fields hold.
- R9: A start raised while busy is remembered, and the next frame begins as soon as the gap expires. Several starts during one frame produce only one further frame.
- R10: lead_stb is 1 for exactly the cycle in which sck has just risen, and trail_stb for exactly the cycle in which it has just fallen. The two are never 1 together.
- R11: busy rises together with cs_n falling and stays high until the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| cont_mode | input | 1 | Continuous-clock mode: gap fixed to one SCK period |
| frame_len | input | LEN_W | SCK pulses per frame minus one |
| baud_pre | input | 2 | SCK prescaler code |
| baud_scl | input | 4 | SCK scaler code |
| dbl_rate | input | 1 | Halves the SCK period |
| csc_pre | input | 2 | Set-up delay prescaler code |
| csc_scl | input | 4 | Set-up delay scaler code |
| asc_pre | input | 2 | Hold delay prescaler code |
| asc_scl | input | 4 | Hold delay scaler code |
| dt_pre | input | 2 | Inter-frame gap prescaler code |
| dt_scl | input | 4 | Inter-frame gap scaler code |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| lead_stb | output | 1 | Pulse on each SCK rise |
| trail_stb | output | 1 | Pulse on each SCK fall |
| busy | output | 1 | Frame or gap in progress |

## Verification
The assertions check on every cycle the relations that hold between outputs at any time: the quiet idle state, SCK confined to the chip-select window, busy covering the chip select, and each strobe matching its SCK edge. Cycle counts cannot be seen from one cycle alone. These are the phase lengths, the three delays, the scaler tables, the pulse count, the clamp at a two-clock period and the way pending requests merge, and the bench's directed scenarios measure them between recorded edges and compare them with values computed from the requirements.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } seq_state_e;

  // Odd prescaler: code c -> 2c+1
  function automatic logic [31:0] pre_factor(input logic [1:0] c);
    return 32'(c) * 32'd2 + 32'd1;
  endfunction

  // Baud scaler: linear steps of two below code 3, powers of two from there
  function automatic logic [31:0] baud_scale(input logic [3:0] c);
    if (c < 4'd3) return 32'(c) * 32'd2 + 32'd2;
    else          return 32'd1 << c;
  endfunction

  // Delay scaler: code n -> 2^(n+1)
  function automatic logic [31:0] dly_scale(input logic [3:0] c);
    return 32'd1 << (32'(c) + 32'd1);
  endfunction

endpackage

// File: rtl/spi_sck_phase.sv
module spi_sck_phase
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [1:0]       pre_code,
  input  logic [3:0]       scl_code,
  input  logic             dbl,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] per_len
);
  localparam logic [31:0] MIN_PER = 32'd2;

  logic [31:0] full;
  logic [31:0] per;

  always_comb begin
    full = pre_factor(pre_code) * baud_scale(scl_code);
    per  = dbl ? (full >> 1) : full;
    if (per < MIN_PER) per = MIN_PER;
    hi_len  = CNT_W'((per + 32'd1) >> 1);
    lo_len  = CNT_W'(per >> 1);
    per_len = CNT_W'(per);
  end
endmodule

// File: rtl/spi_delay_calc.sv
module spi_delay_calc
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [1:0]       pre_code,
  input  logic [3:0]       scl_code,
  output logic [CNT_W-1:0] len
);
  assign len = CNT_W'(pre_factor(pre_code) * dly_scale(scl_code));
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_mode,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [1:0]       baud_pre,
  input  logic [3:0]       baud_scl,
  input  logic             dbl_rate,
  input  logic [1:0]       csc_pre,
  input  logic [3:0]       csc_scl,
  input  logic [1:0]       asc_pre,
  input  logic [3:0]       asc_scl,
  input  logic [1:0]       dt_pre,
  input  logic [3:0]       dt_scl,
  output logic             sck,
  output logic             cs_n,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             busy
);
  localparam int NDLY    = 3;
  localparam int IDX_CSC = 0;
  localparam int IDX_ASC = 1;
  localparam int IDX_DT  = 2;

  // Timing lengths in system clocks
  logic [CNT_W-1:0] hi_len, lo_len, per_len, gap_len;
  logic [1:0]       dly_pre [NDLY];
  logic [3:0]       dly_scl [NDLY];
  logic [CNT_W-1:0] dly_len [NDLY];

  spi_sck_phase #(.CNT_W(CNT_W)) u_phase (
    .pre_code (baud_pre),
    .scl_code (baud_scl),
    .dbl      (dbl_rate),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .per_len  (per_len)
  );

  assign dly_pre[IDX_CSC] = csc_pre;
  assign dly_scl[IDX_CSC] = csc_scl;
  assign dly_pre[IDX_ASC] = asc_pre;
  assign dly_scl[IDX_ASC] = asc_scl;
  assign dly_pre[IDX_DT]  = dt_pre;
  assign dly_scl[IDX_DT]  = dt_scl;

  for (genvar g = 0; g < NDLY; g++) begin : g_dly
    spi_delay_calc #(.CNT_W(CNT_W)) u_calc (
      .pre_code (dly_pre[g]),
      .scl_code (dly_scl[g]),
      .len      (dly_len[g])
    );
  end

  assign gap_len = cont_mode ? per_len : dly_len[IDX_DT];

  // Sequencer state
  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] bits_left;
  logic             pend;
  logic             sck_q, cs_q, lead_q, trail_q;

  // Named events
  wire cnt_done = (cnt == '0);
  wire last_bit = (bits_left == '0);
  wire go_req   = start | pend;
  wire gap_end  = (state == ST_GAP) && cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      pend      <= 1'b0;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      lead_q    <= 1'b0;
      trail_q   <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (start && state != ST_IDLE) pend <= 1'b1;
      if (state == ST_IDLE) begin
        if (start) begin
          state     <= ST_LEAD;
          cs_q      <= 1'b0;
          cnt       <= dly_len[IDX_CSC] - 1'b1;
          bits_left <= frame_len;
        end
      end else if (!cnt_done) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (state)
          ST_LEAD, ST_LOW: begin
            sck_q  <= 1'b1;
            lead_q <= 1'b1;
            state  <= ST_HIGH;
            cnt    <= hi_len - 1'b1;
          end
          ST_HIGH: begin
            sck_q   <= 1'b0;
            trail_q <= 1'b1;
            if (last_bit) begin
              state <= ST_TAIL;
              cnt   <= dly_len[IDX_ASC] - 1'b1;
            end else begin
              state     <= ST_LOW;
              bits_left <= bits_left - 1'b1;
              cnt       <= lo_len - 1'b1;
            end
          end
          ST_TAIL: begin
            cs_q  <= 1'b1;
            state <= ST_GAP;
            cnt   <= gap_len - 1'b1;
          end
          ST_GAP: begin
            if (go_req) begin
              state     <= ST_LEAD;
              cs_q      <= 1'b0;
              cnt       <= dly_len[IDX_CSC] - 1'b1;
              bits_left <= frame_len;
              pend      <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sck       = sck_q;
  assign cs_n      = cs_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic lead_stb,
  input logic trail_stb,
  input logic busy
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck && !lead_stb && !trail_stb));

  p_sck_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  p_setup_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  p_lead_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb == $rose(sck));

  p_trail_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb == $fell(sck));

  p_cs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(cs_n));
endmodule

bind spi_frame_seq spi_frame_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck       (sck),
  .cs_n      (cs_n),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .busy      (busy)
);

// File: tb/spi_frame_seq_bench.sv
module spi_frame_seq_bench;
  localparam int LEN_W = 5;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cont_mode = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [1:0] baud_pre = '0, csc_pre = '0, asc_pre = '0, dt_pre = '0;
  logic [3:0] baud_scl = '0, csc_scl = '0, asc_scl = '0, dt_scl = '0;
  logic dbl_rate = 1'b0;
  logic sck, cs_n, lead_stb, trail_stb, busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  spi_frame_seq #(.CNT_W(20), .LEN_W(LEN_W)) u_spi_frame_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
    .frame_len(frame_len), .baud_pre(baud_pre), .baud_scl(baud_scl),
    .dbl_rate(dbl_rate), .csc_pre(csc_pre), .csc_scl(csc_scl),
    .asc_pre(asc_pre), .asc_scl(asc_scl), .dt_pre(dt_pre), .dt_scl(dt_scl),
    .sck(sck), .cs_n(cs_n), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .busy(busy)
  );

  // ---------------- edge monitor ----------------
  int t_cs_fall, t_cs_rise, t_first_rise, t_last_rise, t_last_fall, t_busy_fall;
  int n_rise, n_frames, last_gap, strobe_err;
  int hi_min, hi_max, lo_min, lo_max;
  logic p_sck = 1'b0, p_cs = 1'b1, p_busy = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        if (t_cs_rise >= 0) last_gap = cyc - t_cs_rise;
        t_cs_fall = cyc;
        n_frames++;
        n_rise = 0;
        hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30; lo_max = 0;
      end
      if (!p_cs && cs_n) t_cs_rise = cyc;
      if (!p_sck && sck) begin
        if (n_rise == 0) t_first_rise = cyc;
        else begin
          if (cyc - t_last_fall < lo_min) lo_min = cyc - t_last_fall;
          if (cyc - t_last_fall > lo_max) lo_max = cyc - t_last_fall;
        end
        t_last_rise = cyc;
        n_rise++;
      end
      if (p_sck && !sck) begin
        if (cyc - t_last_rise < hi_min) hi_min = cyc - t_last_rise;
        if (cyc - t_last_rise > hi_max) hi_max = cyc - t_last_rise;
        t_last_fall = cyc;
      end
      if (p_busy && !busy) t_busy_fall = cyc;
      if (lead_stb !== (sck && !p_sck)) strobe_err++;
      if (trail_stb !== (!sck && p_sck)) strobe_err++;
      p_sck = sck; p_cs = cs_n; p_busy = busy;
    end
  end

  // ---------------- expected-value helpers ----------------
  function automatic int e_pre(input int c);
    case (c)
      0: return 1;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int e_baud(input int c);
    case (c)
      0: return 2;     1: return 4;     2: return 6;     3: return 8;
      4: return 16;    5: return 32;    6: return 64;    7: return 128;
      8: return 256;   9: return 512;   10: return 1024; 11: return 2048;
      12: return 4096; 13: return 8192; 14: return 16384;
      default: return 32768;
    endcase
  endfunction

  function automatic int e_dly(input int p, input int c);
    return e_pre(p) * (2 ** (c + 1));
  endfunction

  function automatic int e_per();
    int p;
    p = e_pre(int'(baud_pre)) * e_baud(int'(baud_scl));
    if (dbl_rate) p = p / 2;
    if (p < 2) p = 2;
    return p;
  endfunction

  task automatic check(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic clear_stats();
    t_cs_rise = -1; last_gap = -1; n_frames = 0; strobe_err = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  task automatic set_cfg(input int bp, input int bs, input int dbl,
                         input int cp, input int cs, input int ap, input int as_,
                         input int dp, input int ds, input int nlen, input int cm);
    baud_pre = 2'(bp); baud_scl = 4'(bs); dbl_rate = 1'(dbl);
    csc_pre = 2'(cp); csc_scl = 4'(cs); asc_pre = 2'(ap); asc_scl = 4'(as_);
    dt_pre = 2'(dp); dt_scl = 4'(ds); frame_len = LEN_W'(nlen); cont_mode = 1'(cm);
  endtask

  // one frame, every interval measured
  task automatic frame_checks(input string tag, input int nlen);
    int p;
    p = e_per();
    clear_stats();
    pulse_start();
    wait_idle();
    check(t_first_rise - t_cs_fall, e_dly(int'(csc_pre), int'(csc_scl)), "R4", {tag, " setup delay"});
    check(n_rise, nlen + 1, "R5", {tag, " rising edges"});
    check(hi_max, (p + 1) / 2, "R3", {tag, " high max"});
    check(hi_min, (p + 1) / 2, "R2", {tag, " high min"});
    if (nlen > 0) begin
      check(lo_max, p / 2, "R3", {tag, " low max"});
      check(lo_min, p / 2, "R2", {tag, " low min"});
    end
    check(t_cs_rise - t_last_fall, e_dly(int'(asc_pre), int'(asc_scl)), "R6", {tag, " hold delay"});
    check(t_busy_fall - t_cs_rise,
          cont_mode ? p : e_dly(int'(dt_pre), int'(dt_scl)), cont_mode ? "R8" : "R7",
          {tag, " gap to idle"});
    check(strobe_err, 0, "R10", {tag, " strobe mismatches"});
    check(n_frames, 1, "R11", {tag, " frame count"});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk); #1;
    check(int'(cs_n), 1, "R1", "cs_n after reset");
    check(int'(sck), 0, "R1", "sck after reset");
    check(int'(busy), 0, "R1", "busy after reset");
    check(int'(lead_stb | trail_stb), 0, "R1", "strobes after reset");
  endtask

  task automatic t_basic();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 0);
    frame_checks("basic", 7);
  endtask

  task automatic t_dbl_odd();
    set_cfg(1, 2, 1, 1, 0, 0, 1, 0, 0, 2, 0);  // P = 3*6/2 = 9
    frame_checks("dbl odd", 2);
  endtask

  task automatic t_wide();
    set_cfg(2, 4, 0, 1, 3, 3, 1, 0, 0, 1, 0);  // P = 80, setup 48, hold 28
    frame_checks("wide", 1);
  endtask

  task automatic t_clamp();
    set_cfg(0, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0);  // P = 1 -> 2
    frame_checks("clamp", 3);
  endtask

  task automatic t_long_delays();
    set_cfg(0, 3, 0, 0, 14, 0, 15, 0, 0, 0, 0);  // setup 32768, hold 65536
    frame_checks("long", 0);
  endtask

  task automatic t_pending();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 1, 2, 3, 0);  // gap 24
    clear_stats();
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    pulse_start();
    wait_idle();
    check(n_frames, 2, "R9", "frames after merged requests");
    check(last_gap, e_dly(1, 2), "R9", "pending frame gap");
    check(t_busy_fall - t_cs_rise, e_dly(1, 2), "R7", "final gap");
    check(strobe_err, 0, "R10", "strobes in pending run");
  endtask

  task automatic t_cont();
    set_cfg(1, 2, 1, 0, 0, 0, 0, 3, 5, 2, 1);  // P = 9, gap fields ignored
    clear_stats();
    pulse_start();
    pulse_start();
    wait_idle();
    check(n_frames, 2, "R8", "continuous frame count");
    check(last_gap, 9, "R8", "continuous gap between frames");
    check(t_busy_fall - t_cs_rise, 9, "R8", "continuous gap to idle");
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_dbl_odd();
    t_wide();
    t_clamp();
    t_pending();
    t_cont();
    t_long_delays();
    finish_up();
  end
endmodule